// File: doc/BRIEF.md
# Debug Scan Command Decoder

This block sits behind a test access port and turns words shifted into a debug data register into actions. The TAP state machine (not part of this block) supplies the test clock, a shift enable, a capture enable, an update enable and the serial input. Bits enter at the top of a 53-bit scan register and move toward bit 0. On each update the top bit of the register selects one of two command layers. A set top bit is a unit-select command: the two bits beneath it name one of four sub-units, and that choice holds until the next select. A clear top bit is a command for the selected sub-unit. A 4-bit opcode follows it, then either a register index or a 32-bit address and a 16-bit word count.

Valid opcodes become single-cycle strobes. Opcodes that the selected unit does not support are dropped silently. The two processor units each own a 2-bit control register, with a stall bit and a reset bit. A register write sets it. Capture loads it so it can be shifted back out, because reads are done by capturing and then shifting a nop command.

Top module: `dsc_cmd_decoder`

## Requirements
- R1: While the reset is asserted and after it is released, the outputs are as follows. unit_vld is 0, every unit's register index is 0, both control registers are 0, every strobe is 0, burst_addr and burst_len are 0, and tdo is 0.
- R2: An update with scan bit 52 = 1 takes bits 51:50 as the unit number and sets unit_sel to it and unit_vld to 1. The unit numbers are 0 = system bus, 1 = first CPU, 2 = second CPU and 3 = serial port. The selection changes only on a later select command.
- R3: An update with bit 52 = 0 takes the opcode from bits 51:48. With the system bus selected, the opcodes map as follows: 0x0 gives strb_nop; 0x1, 0x2 and 0x3 give strb_bwr bit 0, 1 and 2 (8, 16 and 32 bit); 0x5, 0x6 and 0x7 give strb_brd bit 0, 1 and 2; 0x9 gives strb_rwr; 0xD gives strb_rsel. No other opcode raises a strobe.
- R4: With a CPU unit selected, only 0x0, 0x3, 0x7, 0x9 and 0xD raise strobes. The narrow burst opcodes 0x1, 0x2, 0x5 and 0x6 raise none.
- R5: With the serial-port unit selected, only 0x0 raises a strobe (strb_nop). With no unit selected, no command raises a strobe.
- R6: A strobe is high for exactly the one clock that follows the update edge, and at most one strobe is high at a time.
- R7: An accepted burst opcode latches burst_addr from bits 47:16 and burst_len from bits 15:0. These values hold until the next accepted burst.
- R8: Register select (0xD) loads bit 47 into the index of the selected unit only. reg_idx shows the index of the selected unit, and each unit keeps its own index across unit changes.
- R9: A register write (0x9) to a CPU unit whose index is 0 loads the unit's control register from scan bits 46:45. Bit 45 was shifted in first and is the stall bit; bit 46 is the reset bit. A write under index 1, or to any other unit, changes no control register.
- R10: A capture with a CPU unit selected and index 0 loads that unit's control register into scan bits 1:0 and clears the rest. In every other case a capture clears the whole register.
- R11: tdo always shows scan bit 0. Each shift clock moves the register down one place and puts tdi into bit 52.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset; release is synchronised to tck |
| shift_en | input | 1 | Shift the scan register by one bit |
| capture_en | input | 1 | Load read-back value into the scan register |
| update_en | input | 1 | Decode the scan register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (scan bit 0) |
| unit_sel | output | 2 | Selected sub-unit number |
| unit_vld | output | 1 | A sub-unit has been selected |
| reg_idx | output | 1 | Register index of the selected unit |
| strb_nop | output | 1 | Nop strobe |
| strb_bwr | output | 3 | Burst-write strobes for 8/16/32 bit |
| strb_brd | output | 3 | Burst-read strobes for 8/16/32 bit |
| strb_rwr | output | 1 | Internal-register write strobe |
| strb_rsel | output | 1 | Internal-register select strobe |
| burst_addr | output | 32 | Start address of the last accepted burst |
| burst_len | output | 16 | Word count of the last accepted burst |
| cpu_stall | output | 2 | Stall bit per CPU unit |
| cpu_rst | output | 2 | Reset bit per CPU unit |

## Verification
The assertions check four things on every cycle: strobes are mutually exclusive, a strobe only follows an update, a CPU unit never raises a narrow burst strobe, and nothing fires with no unit selected. They also check that the selection and the control bits stay unchanged except after an update. Only the bench's scenarios can show that the correct fields are taken from the correct bit positions. The same holds for the per-unit index memory across unit switches, for the read-back order on tdo, and for the dropping of writes that go under index 1.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int OPW  = 4;
  localparam int SELW = 2;

  localparam logic [OPW-1:0] OP_NOP  = 4'h0;
  localparam logic [OPW-1:0] OP_BW8  = 4'h1;
  localparam logic [OPW-1:0] OP_BW16 = 4'h2;
  localparam logic [OPW-1:0] OP_BW32 = 4'h3;
  localparam logic [OPW-1:0] OP_BR8  = 4'h5;
  localparam logic [OPW-1:0] OP_BR16 = 4'h6;
  localparam logic [OPW-1:0] OP_BR32 = 4'h7;
  localparam logic [OPW-1:0] OP_RWR  = 4'h9;
  localparam logic [OPW-1:0] OP_RSEL = 4'hD;

  localparam logic [SELW-1:0] UNIT_BUS = 2'd0;
  localparam logic [SELW-1:0] UNIT_SER = 2'd3;

  typedef struct packed {
    logic       nop;
    logic [2:0] bwr;
    logic [2:0] brd;
    logic       rwr;
    logic       rsel;
  } strb_t;
endpackage

// File: rtl/dsc_shifter.sv
module dsc_shifter #(
  parameter int W   = 53,
  parameter int CAPW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            capture_en,
  input  logic            tdi,
  input  logic [CAPW-1:0] cap_val,
  output logic [W-1:0]    sr
);
  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = sr;
    if (capture_en) begin
      sr_d = '0;
      sr_d[CAPW-1:0] = cap_val;
    end else if (shift_en) begin
      sr_d = {tdi, sr[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_d;
  end
endmodule

// File: rtl/dsc_opdec.sv
module dsc_opdec
  import dsc_pkg::*;
(
  input  logic [SELW-1:0] unit,
  input  logic            unit_vld,
  input  logic [OPW-1:0]  op,
  output strb_t           strb
);
  logic is_bus, is_live;

  always_comb begin
    is_bus  = unit_vld && (unit == UNIT_BUS);
    is_live = unit_vld && (unit != UNIT_SER);
    strb    = '0;
    case (op)
      OP_NOP:  strb.nop    = unit_vld;
      OP_BW8:  strb.bwr[0] = is_bus;
      OP_BW16: strb.bwr[1] = is_bus;
      OP_BW32: strb.bwr[2] = is_live;
      OP_BR8:  strb.brd[0] = is_bus;
      OP_BR16: strb.brd[1] = is_bus;
      OP_BR32: strb.brd[2] = is_live;
      OP_RWR:  strb.rwr    = is_live;
      OP_RSEL: strb.rsel   = is_live;
      default: strb = '0;
    endcase
  end
endmodule

// File: rtl/dsc_cpu_ctrl.sv
module dsc_cpu_ctrl #(
  parameter int CTRLW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTRLW-1:0] wdata,
  output logic [CTRLW-1:0] ctrl
);
  logic [CTRLW-1:0] ctrl_d;

  always_comb ctrl_d = wr_en ? wdata : ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_d;
  end
endmodule

// File: rtl/dsc_cmd_decoder.sv
module dsc_cmd_decoder
  import dsc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int IDXW  = 1,
  parameter int CTRLW = 2
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            shift_en,
  input  logic            capture_en,
  input  logic            update_en,
  input  logic            tdi,
  output logic            tdo,
  output logic [1:0]      unit_sel,
  output logic            unit_vld,
  output logic [IDXW-1:0] reg_idx,
  output logic            strb_nop,
  output logic [2:0]      strb_bwr,
  output logic [2:0]      strb_brd,
  output logic            strb_rwr,
  output logic            strb_rsel,
  output logic [AW-1:0]   burst_addr,
  output logic [LW-1:0]   burst_len,
  output logic [1:0]      cpu_stall,
  output logic [1:0]      cpu_rst
);
  localparam int W     = 1 + OPW + AW + LW;
  localparam int NUNIT = 1 << SELW;
  localparam int NCPU  = 2;
  localparam int TOP   = W - 1;
  localparam int OPHI  = TOP - 1;
  localparam int FLD   = OPHI - OPW;
  localparam int WDHI  = FLD - IDXW;

  // reset: asserted at once, released after two tck edges
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [W-1:0]     sr;
  logic [CTRLW-1:0] cap_val;

  dsc_shifter #(.W(W), .CAPW(CTRLW)) u_shift (
    .clk(tck), .rst_n(rst_n_s), .shift_en(shift_en), .capture_en(capture_en),
    .tdi(tdi), .cap_val(cap_val), .sr(sr)
  );

  logic [SELW-1:0] sel_f;
  logic [OPW-1:0]  op_f;
  logic [IDXW-1:0] idx_f;
  logic [AW-1:0]   addr_f;
  logic [LW-1:0]   len_f;
  logic [CTRLW-1:0] wdata_f;

  assign sel_f   = sr[OPHI -: SELW];
  assign op_f    = sr[OPHI -: OPW];
  assign idx_f   = sr[FLD -: IDXW];
  assign addr_f  = sr[FLD -: AW];
  assign len_f   = sr[FLD-AW -: LW];
  assign wdata_f = sr[WDHI -: CTRLW];

  logic [SELW-1:0] unit_q, unit_d;
  logic            vld_q, vld_d;
  logic [IDXW-1:0] idx_q [NUNIT];
  logic [IDXW-1:0] idx_d [NUNIT];
  logic [AW-1:0]   addr_q, addr_d;
  logic [LW-1:0]   len_q, len_d;
  strb_t           dec, strb_q, strb_d;

  dsc_opdec u_dec (.unit(unit_q), .unit_vld(vld_q), .op(op_f), .strb(dec));

  always_comb begin
    strb_d = '0;
    unit_d = unit_q;
    vld_d  = vld_q;
    addr_d = addr_q;
    len_d  = len_q;
    for (int u = 0; u < NUNIT; u++) idx_d[u] = idx_q[u];
    if (update_en) begin
      if (sr[TOP]) begin
        unit_d = sel_f;
        vld_d  = 1'b1;
      end else begin
        strb_d = dec;
        if (dec.rsel) idx_d[unit_q] = idx_f;
        if ((|dec.bwr) || (|dec.brd)) begin
          addr_d = addr_f;
          len_d  = len_f;
        end
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n_s) begin
    if (!rst_n_s) begin
      unit_q <= '0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      strb_q <= '0;
      for (int u = 0; u < NUNIT; u++) idx_q[u] <= '0;
    end else begin
      unit_q <= unit_d;
      vld_q  <= vld_d;
      addr_q <= addr_d;
      len_q  <= len_d;
      strb_q <= strb_d;
      for (int u = 0; u < NUNIT; u++) idx_q[u] <= idx_d[u];
    end
  end

  logic [CTRLW-1:0] ctrl [NCPU];
  logic [NCPU-1:0]  hit;

  for (genvar k = 0; k < NCPU; k++) begin : g_cpu
    logic wr_en;
    assign hit[k] = vld_q && (unit_q == SELW'(k + 1)) && (idx_q[unit_q] == '0);
    assign wr_en  = update_en && !sr[TOP] && dec.rwr && hit[k];
    dsc_cpu_ctrl #(.CTRLW(CTRLW)) u_ctrl (
      .clk(tck), .rst_n(rst_n_s), .wr_en(wr_en), .wdata(wdata_f), .ctrl(ctrl[k])
    );
    assign cpu_stall[k] = ctrl[k][0];
    assign cpu_rst[k]   = ctrl[k][1];
  end

  always_comb begin
    cap_val = '0;
    for (int k = 0; k < NCPU; k++) if (hit[k]) cap_val = ctrl[k];
  end

  assign tdo        = sr[0];
  assign unit_sel   = unit_q;
  assign unit_vld   = vld_q;
  assign reg_idx    = idx_q[unit_q];
  assign strb_nop   = strb_q.nop;
  assign strb_bwr   = strb_q.bwr;
  assign strb_brd   = strb_q.brd;
  assign strb_rwr   = strb_q.rwr;
  assign strb_rsel  = strb_q.rsel;
  assign burst_addr = addr_q;
  assign burst_len  = len_q;
endmodule

// File: rtl/dsc_cmd_decoder_chk.sv
module dsc_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       update_en,
  input logic [1:0] unit_sel,
  input logic       unit_vld,
  input logic       strb_nop,
  input logic [2:0] strb_bwr,
  input logic [2:0] strb_brd,
  input logic       strb_rwr,
  input logic       strb_rsel,
  input logic [1:0] cpu_stall,
  input logic [1:0] cpu_rst
);
  logic [8:0] all_s;
  assign all_s = {strb_nop, strb_bwr, strb_brd, strb_rwr, strb_rsel};

  // R6
  strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_s));

  // R6
  strb_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|all_s) |-> $past(update_en));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(update_en) |-> ($stable(unit_sel) && $stable(unit_vld)));

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(update_en) |-> ($stable(cpu_stall) && $stable(cpu_rst)));

  // R4
  cpu_no_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_vld && (unit_sel == 2'd1 || unit_sel == 2'd2))
      |-> (strb_bwr[1:0] == 2'b00 && strb_brd[1:0] == 2'b00));

  // R5
  no_unit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_vld |-> (all_s == '0));
endmodule

bind dsc_cmd_decoder dsc_cmd_decoder_chk u_chk (
  .clk(tck), .rst_n(rst_n_s), .update_en(update_en),
  .unit_sel(unit_sel), .unit_vld(unit_vld),
  .strb_nop(strb_nop), .strb_bwr(strb_bwr), .strb_brd(strb_brd),
  .strb_rwr(strb_rwr), .strb_rsel(strb_rsel),
  .cpu_stall(cpu_stall), .cpu_rst(cpu_rst)
);

// File: tb/dsc_cmd_decoder_tb.sv
module dsc_cmd_decoder_tb;
  localparam int W = 53;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
  logic tdo, unit_vld, strb_nop, strb_rwr, strb_rsel;
  logic [1:0] unit_sel, cpu_stall, cpu_rst;
  logic [0:0] reg_idx;
  logic [2:0] strb_bwr, strb_brd;
  logic [31:0] burst_addr;
  logic [15:0] burst_len;

  dsc_cmd_decoder u_dut (
    .tck(tck), .trst_n(trst_n), .shift_en(shift_en), .capture_en(capture_en),
    .update_en(update_en), .tdi(tdi), .tdo(tdo), .unit_sel(unit_sel),
    .unit_vld(unit_vld), .reg_idx(reg_idx), .strb_nop(strb_nop),
    .strb_bwr(strb_bwr), .strb_brd(strb_brd), .strb_rwr(strb_rwr),
    .strb_rsel(strb_rsel), .burst_addr(burst_addr), .burst_len(burst_len),
    .cpu_stall(cpu_stall), .cpu_rst(cpu_rst)
  );

  always #2.5 tck = ~tck;

  int checks = 0, errors = 0, cycles = 0;
  bit chk_on = 0;

  // reference model state
  bit q[$];
  bit m_vld;
  int m_sel;
  bit m_idx[4];
  bit [1:0] m_ctrl[2];
  bit e_nop, e_rwr, e_rsel;
  bit [2:0] e_bwr, e_brd;
  bit [31:0] m_addr;
  bit [15:0] m_len;

  task automatic model_reset();
    q.delete();
    for (int i = 0; i < W; i++) q.push_back(1'b0);
    m_vld = 0; m_sel = 0; m_addr = 0; m_len = 0;
    for (int i = 0; i < 4; i++) m_idx[i] = 0;
    m_ctrl[0] = 0; m_ctrl[1] = 0;
    e_nop = 0; e_rwr = 0; e_rsel = 0; e_bwr = 0; e_brd = 0;
  endtask

  always @(posedge tck) begin
    if (!trst_n) model_reset();
    else begin
      e_nop = 0; e_rwr = 0; e_rsel = 0; e_bwr = 0; e_brd = 0;
      if (update_en) begin
        int op;
        bit ok;
        op = {q[1], q[2], q[3], q[4]};
        if (q[0]) begin
          m_sel = {q[1], q[2]};
          m_vld = 1;
        end else if (m_vld) begin
          ok = 0;
          if (op == 0) ok = 1;
          else if (op == 1 || op == 2 || op == 5 || op == 6) ok = (m_sel == 0);
          else if (op == 3 || op == 7 || op == 9 || op == 13) ok = (m_sel != 3);
          if (ok) begin
            case (op)
              0: e_nop = 1;
              1: e_bwr = 3'b001;
              2: e_bwr = 3'b010;
              3: e_bwr = 3'b100;
              5: e_brd = 3'b001;
              6: e_brd = 3'b010;
              7: e_brd = 3'b100;
              9: e_rwr = 1;
              13: e_rsel = 1;
              default: ;
            endcase
            if (e_rsel) m_idx[m_sel] = q[5];
            if (e_rwr && (m_sel == 1 || m_sel == 2) && m_idx[m_sel] == 0)
              m_ctrl[m_sel-1] = {q[6], q[7]};
            if (e_bwr != 0 || e_brd != 0) begin
              for (int i = 0; i < 32; i++) m_addr[31-i] = q[5+i];
              for (int i = 0; i < 16; i++) m_len[15-i] = q[37+i];
            end
          end
        end
      end
      if (capture_en) begin
        for (int i = 0; i < W; i++) q[i] = 0;
        if (m_vld && (m_sel == 1 || m_sel == 2) && m_idx[m_sel] == 0) begin
          q[W-1] = m_ctrl[m_sel-1][0];
          q[W-2] = m_ctrl[m_sel-1][1];
        end
      end else if (shift_en) begin
        q.push_front(tdi);
        void'(q.pop_back());
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge tck) begin
    cycles++;
    if (chk_on) begin
      check("R2 unit_vld", unit_vld, m_vld);
      if (m_vld) check("R2 unit_sel", unit_sel, m_sel);
      check("R3 strb_nop", strb_nop, e_nop);
      check("R3 strb_bwr", strb_bwr, e_bwr);
      check("R3 strb_brd", strb_brd, e_brd);
      check("R3 strb_rwr", strb_rwr, e_rwr);
      check("R3 strb_rsel", strb_rsel, e_rsel);
      check("R7 burst_addr", burst_addr, m_addr);
      check("R7 burst_len", burst_len, m_len);
      check("R8 reg_idx", reg_idx, m_idx[m_sel]);
      check("R9 cpu_stall", cpu_stall, {m_ctrl[1][0], m_ctrl[0][0]});
      check("R9 cpu_rst", cpu_rst, {m_ctrl[1][1], m_ctrl[0][1]});
      check("R11 tdo", tdo, q[W-1]);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic scan(logic [63:0] v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge tck); shift_en = 1'b1; tdi = v[i];
    end
    @(negedge tck); shift_en = 1'b0; tdi = 1'b0;
    @(negedge tck); update_en = 1'b1;
    @(negedge tck); update_en = 1'b0;
  endtask

  task automatic sel_unit(logic [1:0] u);
    scan({61'd0, 1'b1, u}, 3);
  endtask

  task automatic cmd(logic [3:0] op, logic idx);
    scan({58'd0, 1'b0, op, idx}, 6);
  endtask

  task automatic wr_ctrl(logic [1:0] d);
    scan({56'd0, 1'b0, 4'h9, 1'b0, d}, 8);
  endtask

  task automatic burst(logic [3:0] op, logic [31:0] a, logic [15:0] l);
    scan({11'd0, 1'b0, op, a, l}, 53);
  endtask

  task automatic capture();
    @(negedge tck); capture_en = 1'b1;
    @(negedge tck); capture_en = 1'b0;
  endtask

  task automatic shift_one();
    @(negedge tck); shift_en = 1'b1; tdi = 1'b0;
    @(negedge tck); shift_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge tck);
    trst_n = 1'b1;
    repeat (4) @(negedge tck);
    // R1 reset state
    check("R1 unit_vld", unit_vld, 0);
    check("R1 strobes", {strb_nop, strb_bwr, strb_brd, strb_rwr, strb_rsel}, 0);
    check("R1 ctrl", {cpu_stall, cpu_rst}, 0);
    check("R1 reg_idx", reg_idx, 0);
    check("R1 tdo", tdo, 0);
    chk_on = 1;

    // R5 no unit selected: nothing fires
    for (int op = 0; op < 16; op++) cmd(4'(op), 1'b0);

    // R2 R3 R7 system bus
    sel_unit(2'd0);
    check("R2 bus selected", {unit_vld, unit_sel}, 3'b100);
    for (int op = 0; op < 16; op++) cmd(4'(op), 1'b0);
    burst(4'h1, 32'hDEAD_BEEF, 16'h0010);
    burst(4'h6, 32'h1234_5678, 16'hFFFF);
    check("R7 burst fields", {burst_addr, burst_len}, {32'h1234_5678, 16'hFFFF});
    burst(4'h4, 32'h0, 16'h0);
    check("R7 rejected burst keeps fields", burst_addr, 32'h1234_5678);

    // R4 R9 R10 first CPU
    sel_unit(2'd1);
    for (int op = 0; op < 16; op++) cmd(4'(op), 1'b0);
    burst(4'h7, 32'hCAFE_0000, 16'h0004);
    wr_ctrl(2'b01);
    check("R9 stall set", {cpu_rst[0], cpu_stall[0]}, 2'b01);
    capture();
    check("R10 first bit stall", tdo, 1);
    shift_one();
    check("R10 second bit reset", tdo, 0);
    wr_ctrl(2'b10);
    capture();
    check("R10 readback reset first", tdo, 0);
    shift_one();
    check("R10 readback reset second", tdo, 1);

    // R8 R9 index 1 ignores writes
    cmd(4'hD, 1'b1);
    check("R8 idx now 1", reg_idx, 1);
    wr_ctrl(2'b11);
    check("R9 write under idx1 ignored", {cpu_rst[0], cpu_stall[0]}, 2'b10);
    capture();
    check("R10 idx1 reads zero", tdo, 0);

    // R8 second CPU keeps own index 0
    sel_unit(2'd2);
    check("R8 cpu1 idx 0", reg_idx, 0);
    wr_ctrl(2'b11);
    check("R9 cpu1 ctrl", {cpu_rst[1], cpu_stall[1]}, 2'b11);
    check("R9 cpu0 untouched", {cpu_rst[0], cpu_stall[0]}, 2'b10);
    sel_unit(2'd1);
    check("R8 cpu0 idx kept", reg_idx, 1);

    // R5 serial unit: nop only, writes ignored
    sel_unit(2'd3);
    for (int op = 0; op < 16; op++) cmd(4'(op), 1'b1);
    wr_ctrl(2'b00);
    check("R9 serial write no effect", {cpu_rst, cpu_stall}, 4'b1110);
    capture();
    check("R10 serial capture zero", tdo, 0);

    // R11 raw shifting pattern
    for (int i = 0; i < 60; i++) begin
      @(negedge tck); shift_en = 1'b1; tdi = i[0] ^ i[2];
    end
    @(negedge tck); shift_en = 1'b0;

    // R6 back-to-back updates after a single load
    sel_unit(2'd0);
    cmd(4'h3, 1'b0);
    @(negedge tck); update_en = 1'b1;
    @(negedge tck); update_en = 1'b0;
    repeat (3) @(negedge tck);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule